// File: doc/BRIEF.md
# Pipeline Trap and Flush Controller

This block sits beside a five-stage pipeline and turns three event sources into one precise trap. The sources are an illegal-opcode flag raised by decode, an arithmetic-overflow flag raised by execute, and an asynchronous interrupt request. In the cycle an event is seen, the block decides which instruction the event is charged to. It then raises flush strobes that kill that instruction and every younger one, while older instructions drain normally. Fetch is steered to a fixed handler vector in the same cycle.

Each stage is cleared in its own way. The fetch/decode register loads an all-zero instruction word, which is a no-op. The word about to enter execute is replaced by zeroed control. When the overflow comes from execute itself, that stage's own control lines are forced to zero so the instruction writes nothing. On the next clock edge, the PC of the charged instruction and a cause code are captured in two registers that the handler can read.

Top module: `pipe_trap_ctrl`

## Requirements
- R1: After reset `epc` is 0, `cause` is 0, and with all event inputs low no flush strobe and no `redirectValid` is raised.
- R2: When `exValid` and `exOverflow` are both high, `exCtrlFlush`, `idExFlush` and `ifIdFlush` are all high in that same cycle.
- R3: When `idValid` and `idIllegal` are high and there is no execute overflow, `idExFlush` and `ifIdFlush` are high and `exCtrlFlush` stays low, so the older execute instruction completes.
- R4: When `irqReq` is high and neither exception is present, `idExFlush` and `ifIdFlush` are high and `exCtrlFlush` is low. The PC charged is `idPc` when `idValid` is high, otherwise `ifPc`.
- R5: Priority is execute overflow, then decode illegal opcode, then interrupt. The cause codes are 3 for overflow, 2 for illegal instruction and 1 for interrupt, and 0 means that no trap has been taken since reset.
- R6: On the clock edge that ends a cycle with a trap, `epc` loads the charged PC (`exPc` for overflow, `idPc` for illegal) and `cause` loads its code. In cycles without a trap both registers hold their value.
- R7: `idIllegal` is ignored while `idValid` is low, and `exOverflow` is ignored while `exValid` is low.
- R8: `redirectValid` is high exactly in a cycle with a trap, and `redirectPc` then equals parameter `HANDLER_PC` (default 0x40000040). It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ifPc | input | AW | PC of the instruction in fetch |
| idValid | input | 1 | Decode stage holds a real instruction |
| idPc | input | AW | PC of the decode instruction |
| idIllegal | input | 1 | Decode found an illegal opcode |
| exValid | input | 1 | Execute stage holds a real instruction |
| exPc | input | AW | PC of the execute instruction |
| exOverflow | input | 1 | Execute detected arithmetic overflow |
| irqReq | input | 1 | External interrupt request |
| ifIdFlush | output | 1 | Load a zero instruction word into the fetch/decode register |
| idExFlush | output | 1 | Zero the control entering execute |
| exCtrlFlush | output | 1 | Zero the control lines of the execute stage |
| redirectValid | output | 1 | Fetch must take `redirectPc` |
| redirectPc | output | AW | Handler vector |
| epc | output | AW | Saved PC of the charged instruction |
| cause | output | CW | Saved cause code |

## Verification
The bench builds the block with `AW` = 32, `CW` = 4 and the default handler vector, so the vector value of 0x40000040 is checked at full width. The bench sweeps all 32 combinations of the five event and valid inputs in two passes, each with a distinct set of stage PCs. This covers every priority collision, every masked flag, and the interrupt PC choice with decode both full and empty. Each trap is followed by cycles without a trap, so the hold behaviour of the saved registers is checked against a model kept in the bench.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    SRC_EX = 2'd0,
    SRC_ID = 2'd1,
    SRC_IF = 2'd2
  } pcSrcT;

  localparam logic [1:0] CODE_NONE = 2'd0;
  localparam logic [1:0] CODE_IRQ  = 2'd1;
  localparam logic [1:0] CODE_ILL  = 2'd2;
  localparam logic [1:0] CODE_OVF  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       take;
    logic       killEx;
    logic       killId;
    logic       killIf;
    pcSrcT      pcSrc;
    logic [1:0] code;
  } trapStrobeT;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic       idValid,
  input  logic       idIllegal,
  input  logic       exValid,
  input  logic       exOverflow,
  input  logic       irqReq,
  output trapStrobeT strobe
);

  logic ovfHit;
  logic illHit;

  assign ovfHit = exValid & exOverflow;
  assign illHit = idValid & idIllegal;

  always_comb begin
    strobe       = '0;
    strobe.pcSrc = SRC_IF;
    if (ovfHit) begin
      // execute instruction is the oldest offender: kill it and all behind
      strobe.take   = 1'b1;
      strobe.killEx = 1'b1;
      strobe.killId = 1'b1;
      strobe.killIf = 1'b1;
      strobe.pcSrc  = SRC_EX;
      strobe.code   = CODE_OVF;
    end else if (illHit) begin
      // execute instruction is older and finishes
      strobe.take   = 1'b1;
      strobe.killId = 1'b1;
      strobe.killIf = 1'b1;
      strobe.pcSrc  = SRC_ID;
      strobe.code   = CODE_ILL;
    end else if (irqReq) begin
      // execute finishes; oldest killed instruction is the restart point
      strobe.take   = 1'b1;
      strobe.killId = 1'b1;
      strobe.killIf = 1'b1;
      strobe.pcSrc  = idValid ? SRC_ID : SRC_IF;
      strobe.code   = CODE_IRQ;
    end
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          CW         = 4,
  parameter logic [AW-1:0] HANDLER_PC = AW'(32'h4000_0040)
) (
  input  logic          clk,
  input  logic          rstN,
  input  trapStrobeT    strobe,
  input  logic [AW-1:0] ifPc,
  input  logic [AW-1:0] idPc,
  input  logic [AW-1:0] exPc,
  output logic          ifIdFlush,
  output logic          idExFlush,
  output logic          exCtrlFlush,
  output logic          redirectValid,
  output logic [AW-1:0] redirectPc,
  output logic [AW-1:0] epc,
  output logic [CW-1:0] cause
);

  logic [AW-1:0] chargedPc;
  logic [AW-1:0] epcQ;
  logic [CW-1:0] causeQ;

  always_comb begin
    unique case (strobe.pcSrc)
      SRC_EX:  chargedPc = exPc;
      SRC_ID:  chargedPc = idPc;
      default: chargedPc = ifPc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcQ   <= '0;
      causeQ <= '0;
    end else if (strobe.take) begin
      epcQ   <= chargedPc;
      causeQ <= CW'(strobe.code);
    end
  end

  assign ifIdFlush     = strobe.killIf;
  assign idExFlush     = strobe.killId;
  assign exCtrlFlush   = strobe.killEx;
  assign redirectValid = strobe.take;
  assign redirectPc    = strobe.take ? HANDLER_PC : '0;
  assign epc           = epcQ;
  assign cause         = causeQ;

endmodule

// File: rtl/pipe_trap_ctrl.sv
module pipe_trap_ctrl
  import trap_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            CW         = 4,
  parameter logic [AW-1:0] HANDLER_PC = AW'(32'h4000_0040)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] ifPc,
  input  logic          idValid,
  input  logic [AW-1:0] idPc,
  input  logic          idIllegal,
  input  logic          exValid,
  input  logic [AW-1:0] exPc,
  input  logic          exOverflow,
  input  logic          irqReq,
  output logic          ifIdFlush,
  output logic          idExFlush,
  output logic          exCtrlFlush,
  output logic          redirectValid,
  output logic [AW-1:0] redirectPc,
  output logic [AW-1:0] epc,
  output logic [CW-1:0] cause
);

  trapStrobeT strobe;

  trap_ctrl u_ctrl (
    .idValid    (idValid),
    .idIllegal  (idIllegal),
    .exValid    (exValid),
    .exOverflow (exOverflow),
    .irqReq     (irqReq),
    .strobe     (strobe)
  );

  trap_dp #(
    .AW         (AW),
    .CW         (CW),
    .HANDLER_PC (HANDLER_PC)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .ifPc          (ifPc),
    .idPc          (idPc),
    .exPc          (exPc),
    .ifIdFlush     (ifIdFlush),
    .idExFlush     (idExFlush),
    .exCtrlFlush   (exCtrlFlush),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .epc           (epc),
    .cause         (cause)
  );

endmodule

// File: rtl/trap_checker.sv
module trap_checker #(
  parameter int            AW         = 32,
  parameter int            CW         = 4,
  parameter logic [AW-1:0] HANDLER_PC = AW'(32'h4000_0040)
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] ifPc,
  input logic          idValid,
  input logic [AW-1:0] idPc,
  input logic          idIllegal,
  input logic          exValid,
  input logic [AW-1:0] exPc,
  input logic          exOverflow,
  input logic          irqReq,
  input logic          ifIdFlush,
  input logic          idExFlush,
  input logic          exCtrlFlush,
  input logic          redirectValid,
  input logic [AW-1:0] redirectPc,
  input logic [AW-1:0] epc,
  input logic [CW-1:0] cause
);

  a_r2_ovf_kills_all: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exOverflow) |-> (exCtrlFlush && idExFlush && ifIdFlush));

  a_r3_ex_survives: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && idIllegal && !(exValid && exOverflow)) |-> (!exCtrlFlush && idExFlush && ifIdFlush));

  a_r4_irq_flush: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !(exValid && exOverflow) && !(idValid && idIllegal)) |-> (!exCtrlFlush && ifIdFlush));

  a_r5_ovf_code: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exOverflow) |=> (cause == CW'(3) && epc == $past(exPc)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |=> ($stable(epc) && $stable(cause)));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && !(exValid && exOverflow) && !(idValid && idIllegal)) |-> (!redirectValid && !ifIdFlush && !idExFlush && !exCtrlFlush));

  a_r8_vector: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectPc == HANDLER_PC && ifIdFlush));

endmodule

bind pipe_trap_ctrl trap_checker #(.AW(AW), .CW(CW), .HANDLER_PC(HANDLER_PC)) u_trap_checker (.*);

// File: tb/test_pipe_trap_ctrl.sv
module test_pipe_trap_ctrl;

  localparam int AW = 32;
  localparam int CW = 4;
  localparam logic [AW-1:0] VEC = 32'h4000_0040;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] ifPc = '0, idPc = '0, exPc = '0;
  logic          idValid = 1'b0, idIllegal = 1'b0, exValid = 1'b0, exOverflow = 1'b0, irqReq = 1'b0;
  logic          ifIdFlush, idExFlush, exCtrlFlush, redirectValid;
  logic [AW-1:0] redirectPc, epc;
  logic [CW-1:0] cause;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] expEpc = '0;
  logic [CW-1:0] expCause = '0;

  always #5 clk = ~clk;

  pipe_trap_ctrl #(.AW(AW), .CW(CW), .HANDLER_PC(VEC)) i_pipe_trap_ctrl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ovf, ill, take, eF, iF, fF;
    logic [AW-1:0] chPc;
    logic [CW-1:0] code;
    repeat (2) @(negedge clk);
    // R1: reset values
    chk("R1 epc", epc, 0);
    chk("R1 cause", cause, 0);
    chk("R1 redirect", redirectValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle flush", {ifIdFlush, idExFlush, exCtrlFlush}, 0);
    chk("R1 epc after reset", epc, 0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 32; v++) begin
        @(negedge clk);
        {idValid, idIllegal, exValid, exOverflow, irqReq} = 5'(v);
        ifPc = 32'h0000_1000 + 32'(pass * 32'h100) + 32'(v * 4);
        idPc = 32'h0020_0000 + 32'(pass * 32'h100) + 32'(v * 8);
        exPc = 32'h0300_0000 + 32'(pass * 32'h100) + 32'(v * 12);
        ovf = exValid & exOverflow;
        ill = idValid & idIllegal;
        take = ovf | ill | irqReq;
        eF = ovf;
        iF = take;
        fF = take;
        if (ovf) begin chPc = exPc; code = 3; end
        else if (ill) begin chPc = idPc; code = 2; end
        else if (irqReq) begin chPc = idValid ? idPc : ifPc; code = 1; end
        else begin chPc = expEpc; code = expCause; end
        #2;
        // R2/R3/R4/R7 flush strobes
        if (ovf) chk("R2 flush", {ifIdFlush, idExFlush, exCtrlFlush}, {fF, iF, eF});
        else if (ill) chk("R3 flush", {ifIdFlush, idExFlush, exCtrlFlush}, {fF, iF, eF});
        else if (irqReq) chk("R4 flush", {ifIdFlush, idExFlush, exCtrlFlush}, {fF, iF, eF});
        else chk("R7 masked flags", {ifIdFlush, idExFlush, exCtrlFlush}, 0);
        chk("R8 redirectValid", redirectValid, take);
        chk("R8 redirectPc", redirectPc, take ? VEC : 0);
        @(posedge clk);
        #1;
        if (take) begin expEpc = chPc; expCause = code; end
        chk("R5 cause", cause, expCause);
        chk(irqReq && !ovf && !ill ? "R4 epc" : "R6 epc", epc, expEpc);
        // quiet cycle: R6 hold
        @(negedge clk);
        {idValid, idIllegal, exValid, exOverflow, irqReq} = 5'b0;
        @(posedge clk);
        #1;
        chk("R6 hold epc", epc, expEpc);
        chk("R6 hold cause", cause, expCause);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule